// File: doc/BRIEF.md
# Two-Digit BCD Down Counter

This block is a synchronous down counter that holds a value from 00 to 99 as two packed BCD digits. On each rising clock edge it steps down by one decimal count while its active-low count enable is asserted. From 00 it wraps back to 99, so a free-running counter repeats every 100 clocks. A decade borrow moves from the low digit into the high digit whenever the low digit passes zero.

The count can be set from an 8-bit parallel load value in two ways. An asynchronous load takes effect at once, without the clock. A synchronous load takes effect on the next rising edge. An active-low master clear forces the count to 99 at any time. The controls act in a fixed order of precedence: clear, then asynchronous load, then synchronous load, then count or hold.

An active-low terminal flag is derived combinationally from the count and the enable. The flag is asserted only when the count is 00 and counting is enabled. This lets the flag of one stage drive the enable of the next stage when stages are chained.

Top module: `bcd_dn_counter`

## Requirements
- R1: While `clr_max_n` is low, `count` is 8'h99 at once, without a clock edge, whatever the other inputs are doing.
- R2: While `clr_max_n` is high and `aload_n` is low, `count` equals `load_val` at once, without a clock edge. This holds whatever `sload_n`, `cnt_en_n` and the clock are doing.
- R3: With both asynchronous controls high and `sload_n` low, `count` takes `load_val` on the next rising edge, whether `cnt_en_n` is high or low.
- R4: With all load and clear controls high and `cnt_en_n` high, `count` does not change across clock edges.
- R5: With all load and clear controls high and `cnt_en_n` low, each rising edge lowers the decimal count by one. A low digit of 0 becomes 9 and borrows one from the high digit; for example, 8'h10 becomes 8'h09.
- R6: When counting from 8'h00, the next count is 8'h99, so free counting repeats every 100 clocks.
- R7: `tc_n` is low exactly when `count` is 8'h00 and `cnt_en_n` is low. While counting, it is low for exactly one clock period in each 100-clock cycle.
- R8: `load_val[7:4]` is the tens digit and `load_val[3:0]` is the units digit. `count` uses the same layout.
- R9: A digit holding 10 to 15 steps down by one in binary on each count, with no borrow, until it reaches a valid value; for example, 8'hFA becomes 8'hF9 and 8'h0F becomes 8'h0E. A borrow still passes into a digit of 10 to 15, so 8'hA0 becomes 8'h99.
- R10: With `cnt_en_n` low, an asynchronous load of 8'h00 drives `tc_n` low at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_max_n | input | 1 | Asynchronous clear to 99, active low |
| aload_n | input | 1 | Asynchronous load of `load_val`, active low |
| sload_n | input | 1 | Synchronous load of `load_val`, active low |
| cnt_en_n | input | 1 | Count enable, active low; also gates `tc_n` |
| load_val | input | 8 | Two packed BCD digits to load |
| count | output | 8 | Current count, two packed BCD digits |
| tc_n | output | 1 | Terminal flag, active low |

## Verification
The hardest conditions to reach from the ports are the ones that only a load can create: digit values of 10 to 15, and a terminal flag that falls with no clock edge. The stimulus uses the synchronous load to place 8'hFA, 8'hA0 and 8'h0F in the counter, then counts, which covers the binary recovery and the borrow into an invalid digit. It drives the asynchronous load and the clear halfway between clock edges and samples the outputs before the next rising edge. This shows that the count and `tc_n` change without the clock, and that the clear dominates an active asynchronous load.

// File: rtl/bcd_dn_pkg.sv
// Shared constants and types for the BCD down counter.
// Assumes 4-bit decimal digits packed with the most significant digit highest.
package bcd_dn_pkg;
    localparam int DIG_W = 4;
    localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;

    // Synchronous action selected for the next rising edge
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2
    } sync_mode_e;
endpackage

// File: rtl/bcd_digit_dec.sv
// One decimal digit of the down counter: next value and borrow out.
// Assumes borrow_in high means "decrement this digit now".
// Digits above 9 step down in binary and never borrow.
module bcd_digit_dec
    import bcd_dn_pkg::*;
(
    input  logic [DIG_W-1:0] digit,
    input  logic             borrow_in,
    output logic [DIG_W-1:0] digit_nxt,
    output logic             borrow_out
);
    // Next digit value and borrow toward the more significant digit
    always_comb begin
        digit_nxt  = digit;
        borrow_out = 1'b0;
        if (borrow_in) begin
            if (digit == '0) begin
                digit_nxt  = DIG_MAX;
                borrow_out = 1'b1;
            end else begin
                digit_nxt  = digit - 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcd_dn_ctrl.sv
// Decodes the synchronous controls into the action for the next edge.
// Assumes the asynchronous clear and load are handled in the count register.
module bcd_dn_ctrl
    import bcd_dn_pkg::*;
(
    input  logic       sload_n,
    input  logic       cnt_en_n,
    output sync_mode_e mode
);
    // The synchronous load wins over counting, and counting over holding
    always_comb begin
        if (!sload_n)
            mode = MODE_LOAD;
        else if (!cnt_en_n)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/bcd_tc_gen.sv
// Terminal flag: active low when every bit of the count is zero and counting is enabled.
// Combinational, so it follows asynchronous changes of the count directly.
module bcd_tc_gen #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic         cnt_en_n,
    output logic         tc_n
);
    logic all_zero;

    // Zero detect of the whole count
    always_comb all_zero = (cnt == '0);

    // Gate the zero detect with the enable so chained stages see one terminal cycle
    always_comb tc_n = ~(all_zero & ~cnt_en_n);
endmodule

// File: rtl/bcd_dn_counter.sv
// Cascadable multi-digit BCD down counter (two digits by default).
// Precedence: clear to all-nines, asynchronous load, synchronous load, count, hold.
// Assumes load_val is stable while aload_n is low; the register reloads it on every clock edge in that state.
module bcd_dn_counter
    import bcd_dn_pkg::*;
#(
    parameter int NDIG = 2
) (
    input  logic                  clk,
    input  logic                  clr_max_n,
    input  logic                  aload_n,
    input  logic                  sload_n,
    input  logic                  cnt_en_n,
    input  logic [NDIG*DIG_W-1:0] load_val,
    output logic [NDIG*DIG_W-1:0] count,
    output logic                  tc_n
);
    localparam int CW = NDIG * DIG_W;
    localparam logic [CW-1:0] MAX_CNT = {NDIG{DIG_MAX}};

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_dec;
    logic [NDIG:0] borrow;
    sync_mode_e    mode;

    assign borrow[0] = 1'b1;

    // Borrow chain from the units digit upward
    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        bcd_digit_dec u_dig (
            .digit      (cnt_q[g*DIG_W +: DIG_W]),
            .borrow_in  (borrow[g]),
            .digit_nxt  (cnt_dec[g*DIG_W +: DIG_W]),
            .borrow_out (borrow[g+1])
        );
    end

    bcd_dn_ctrl u_ctrl (
        .sload_n  (sload_n),
        .cnt_en_n (cnt_en_n),
        .mode     (mode)
    );

    // Count register with asynchronous clear and asynchronous load
    always_ff @(posedge clk or negedge clr_max_n or negedge aload_n) begin
        if (!clr_max_n)
            cnt_q <= MAX_CNT;
        else if (!aload_n)
            cnt_q <= load_val;
        else begin
            case (mode)
                MODE_LOAD:  cnt_q <= load_val;
                MODE_COUNT: cnt_q <= cnt_dec;
                default:    cnt_q <= cnt_q;
            endcase
        end
    end

    bcd_tc_gen #(.W(CW)) u_tc (
        .cnt      (cnt_q),
        .cnt_en_n (cnt_en_n),
        .tc_n     (tc_n)
    );

    assign count = cnt_q;
endmodule

// File: rtl/bcd_dn_counter_chk.sv
// Property checker for bcd_dn_counter (two-digit configuration), bound to every instance.
// Assumes the asynchronous controls change away from rising clock edges and stay asserted across at least one edge.
module bcd_dn_counter_chk (
    input logic       clk,
    input logic       clr_max_n,
    input logic       aload_n,
    input logic       sload_n,
    input logic       cnt_en_n,
    input logic [7:0] load_val,
    input logic [7:0] count,
    input logic       tc_n
);
    // Decimal value of two packed digits
    function automatic int dec_of(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    logic sync_ok;
    logic counting;
    assign sync_ok  = clr_max_n && aload_n;
    assign counting = sync_ok && sload_n && !cnt_en_n;

    // R1: clear holds the count at all-nines
    always @(posedge clk) begin
        if (!clr_max_n)
            a_r1_clear_max: assert (count == 8'h99);
    end

    // R2: asynchronous load tracks the load value
    always @(posedge clk) begin
        if (clr_max_n && !aload_n)
            a_r2_async_load: assert (count == load_val);
    end

    a_r3_sync_load: assert property (@(posedge clk) disable iff (!clr_max_n)
        ($past(sync_ok && !sload_n) && aload_n) |-> (count == $past(load_val)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!clr_max_n)
        ($past(sync_ok && sload_n && cnt_en_n) && aload_n) |-> $stable(count));

    a_r5_step_down: assert property (@(posedge clk) disable iff (!clr_max_n)
        ($past(counting) && aload_n && $past(count) != 8'h00 &&
         $past(count[7:4]) <= 4'd9 && $past(count[3:0]) <= 4'd9)
        |-> (dec_of(count) == dec_of($past(count)) - 1));

    a_r6_wrap: assert property (@(posedge clk) disable iff (!clr_max_n)
        ($past(counting) && aload_n && $past(count) == 8'h00) |-> (count == 8'h99));

    a_r7_terminal: assert property (@(posedge clk) disable iff (!clr_max_n)
        ($past(counting) && aload_n && $past(count) == 8'h01 && !cnt_en_n) |-> !tc_n);

    a_r9_invalid_low: assert property (@(posedge clk) disable iff (!clr_max_n)
        ($past(counting) && aload_n && $past(count[3:0]) > 4'd9)
        |-> (count[3:0] == $past(count[3:0]) - 4'd1 && count[7:4] == $past(count[7:4])));
endmodule

bind bcd_dn_counter bcd_dn_counter_chk u_chk (
    .clk       (clk),
    .clr_max_n (clr_max_n),
    .aload_n   (aload_n),
    .sload_n   (sload_n),
    .cnt_en_n  (cnt_en_n),
    .load_val  (load_val),
    .count     (count),
    .tc_n      (tc_n)
);

// File: tb/bcd_dn_counter_tb.sv
// Scoreboard bench: the driver task applies one cycle of stimulus at the falling edge and queues the expected result;
// the monitor checks each queued item just after the following rising edge.
module bcd_dn_counter_tb;
    logic       clk = 1'b0;
    logic       clr_max_n = 1'b1;
    logic       aload_n = 1'b1;
    logic       sload_n = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic [7:0] load_val = 8'h00;
    logic [7:0] count;
    logic       tc_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] model = 8'h99;

    typedef struct {
        logic [7:0] cnt;
        logic       tc;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    bcd_dn_counter u_dut (
        .clk       (clk),
        .clr_max_n (clr_max_n),
        .aload_n   (aload_n),
        .sload_n   (sload_n),
        .cnt_en_n  (cnt_en_n),
        .load_val  (load_val),
        .count     (count),
        .tc_n      (tc_n)
    );

    // One digit step from R5 and R9: 0 goes to 9 with a borrow, anything else drops by one
    function automatic logic [7:0] step_down(input logic [7:0] v);
        logic [3:0] lo, hi;
        lo = v[3:0];
        hi = v[7:4];
        if (lo == 4'd0) begin
            lo = 4'd9;
            hi = (hi == 4'd0) ? 4'd9 : hi - 4'd1;
        end else begin
            lo = lo - 4'd1;
        end
        return {hi, lo};
    endfunction

    task automatic check(input string tag, input logic [7:0] c_act, input logic c_tc,
                         input logic [7:0] c_exp, input logic e_tc);
        n_tests++;
        if (c_act !== c_exp || c_tc !== e_tc) begin
            n_fail++;
            $display("FAIL %s: count=%h tc_n=%b expected count=%h tc_n=%b", tag, c_act, c_tc, c_exp, e_tc);
        end
    endtask

    // Apply one cycle of controls, update the model, optionally check the immediate response
    task automatic drive(input logic r, input logic a, input logic s, input logic e,
                         input logic [7:0] j, input string tag, input bit imm);
        exp_t it;
        @(negedge clk);
        clr_max_n = r; aload_n = a; sload_n = s; cnt_en_n = e; load_val = j;
        if (!r)      model = 8'h99;
        else if (!a) model = j;
        else if (!s) model = j;
        else if (!e) model = step_down(model);
        it.cnt = model;
        it.tc  = !(model == 8'h00 && !e);
        it.tag = tag;
        if (imm) begin
            #1;
            check({tag, " immediate"}, count, tc_n, it.cnt, it.tc);
        end
        sb.push_back(it);
    endtask

    // Monitor: compare one queued expectation after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(it.tag, count, tc_n, it.cnt, it.tc);
        end
    end

    initial begin
        #1 clr_max_n = 1'b0;
        #0.5 check("R1 reset", count, tc_n, 8'h99, 1'b1);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R1", 1'b0);
        // R4: hold with enable high
        repeat (3) drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R4", 1'b0);
        // R5 R6 R7: full 100-clock cycle from 99 back to 99
        for (int i = 0; i < 100; i++) drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5/R6/R7", 1'b0);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5 after wrap", 1'b0);
        // R3: synchronous load ignores the enable
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h42, "R3 enable high", 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h17, "R3 enable low", 1'b0);
        for (int i = 0; i < 9; i++) drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5 borrow", 1'b0);
        repeat (2) drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R4 hold", 1'b0);
        // R8: digit layout of the load value
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h58, "R8 load", 1'b0);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R8 count", 1'b0);
        // R2: asynchronous load overrides the synchronous load and counting
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h63, "R2", 1'b1);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h63, "R2 held", 1'b0);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R2 release", 1'b0);
        // R9: invalid digits recover in binary
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'hFA, "R9 load FA", 1'b0);
        repeat (3) drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R9 FA", 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'hA0, "R9 load A0", 1'b0);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R9 A0", 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h0F, "R9 load 0F", 1'b0);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R9 0F", 1'b0);
        // R10: asynchronous load of zero drives the terminal flag at once
        drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R10", 1'b1);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R10 disabled", 1'b0);
        // R1: clear dominates an active asynchronous load
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h12, "R1 over load", 1'b1);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1 release", 1'b0);
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: count=%h tc_n=%b expected run to finish", count, tc_n);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule